// File: doc/BRIEF.md
# Two-Core Montgomery Modular Exponentiator

This block raises a base to a power modulo an odd modulus, returning `x^e mod M` for an N-bit modulus. The caller provides the base, the exponent, the modulus, the precomputed constant `R^2 mod M` (with `R = 2^N`) and the number of exponent bits `t` to use. A one-cycle `start_i` pulse begins the operation. The result appears on `z_o`, and `done_o` pulses for one cycle when it is ready.

The block contains two bit-serial radix-2 Montgomery multipliers and a controller. The first operation is a conversion step. Core A maps the base into the Montgomery domain. In the same step, core B forms `R mod M`, which is the Montgomery image of one and seeds the accumulator.

The exponent is then read from its least significant bit upward. In each step, core A squares the running power. When the current exponent bit is set, core B multiplies that same power into the accumulator at the same time. A last product with one maps the accumulator back to an ordinary residue. The schedule has the same length whatever the exponent bits are.

Top module: `mont_pow`

## Requirements
- R1: For an odd modulus `M` in [3, 2^N), a base `x < M`, and `r2_i = 2^(2N) mod M`, the block returns `z_o = x^E mod M`. Here `E` is made of exponent bits 0 to `t-1`.
- R2: Exponent bits at positions `t` and above have no effect on `z_o`. An `exp_len_i` value greater than EW is treated as EW.
- R3: With `exp_len_i = 0`, the result is `1`.
- R4: Latency is fixed. Count the clock edge that samples `start_i` as the first. `done_o` is high after edge number `(t+2)*(N+2)`, whatever the exponent bit values are.
- R5: `done_o` is high for exactly one cycle. `z_o` keeps its value from that cycle until the next operation completes.
- R6: A `start_i` pulse that arrives while an operation is running is ignored. The operands on the inputs at that moment are ignored as well. Both the result and the latency stay those of the running operation.
- R7: While reset (`rst_n`) is low, `done_o` is 0 and `z_o` is 0.
- R8: For an exponent bit of 0, the multiply core does not run in that step and the accumulator keeps its value.
- R9: Both products of a step read the squared value as it stood at the start of the step. The new square and the new accumulator are written only when the step finishes.
- R10: Each product ends with at most one subtraction of `M`. The result is therefore always below `M`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| base_i | input | N | Base `x`, below the modulus |
| exp_i | input | EW | Exponent bits, LSB first in use |
| mod_i | input | N | Odd modulus `M` |
| r2_i | input | N | `2^(2N) mod M` |
| exp_len_i | input | clog2(EW+1) | Number of exponent bits `t` to use |
| z_o | output | N | Result `x^E mod M` |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The block is driven with random odd moduli, random bases and random exponent lengths, and each result is compared against a plain square-and-multiply model computed in the bench.

Directed cases separate the following behaviours:
- Single-bit exponents (`e = 1` and only the top bit set) exercise the multiply core in just one step.
- A dense all-ones exponent with the largest modulus stresses the final subtraction.
- A zero base, a zero exponent length, and a window that hides set high bits isolate the conversion-only paths.
- A length above EW checks the clamp.

On every run the latency is checked against the exponent length. One run also receives a second start pulse with different operands partway through, to show that the block does not retrigger.

// File: rtl/mont_pow.sv
module mont_pow #(
  parameter int N  = 16,
  parameter int EW = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [N-1:0]               base_i,
  input  logic [EW-1:0]              exp_i,
  input  logic [N-1:0]               mod_i,
  input  logic [N-1:0]               r2_i,
  input  logic [$clog2(EW+1)-1:0]    exp_len_i,
  output logic [N-1:0]               z_o,
  output logic                       done_o
);
  localparam int LW = $clog2(EW+1);
  localparam int IW = (EW > 1) ? $clog2(EW) : 1;
  localparam int CW = $clog2(N+1);

  typedef enum logic [2:0] {IDLE, CONV, STEP_LD, STEP, FIN_LD, FIN, DONE} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [N-1:0]    m_q, s_q, u_q;
  logic [EW-1:0]   e_q;
  logic [LW-1:0]   t_q, i_q;
  logic            en1;

  logic [1:0][N-1:0] xa, yb;
  logic [1:0][N:0]   acc;
  logic [1:0][N+1:0] p0, p1;
  logic [1:0][N:0]   nx;
  logic [1:0][N-1:0] rd;

  wire busy = (st == CONV) || (st == STEP) || (st == FIN);
  wire last = busy && (cnt == CW'(N));

  for (genvar k = 0; k < 2; k++) begin : g_core
    always_comb begin
      p0[k] = {1'b0, acc[k]} + (xa[k][0] ? {2'b0, yb[k]} : '0);
      p1[k] = p0[k] + (p0[k][0] ? {2'b0, m_q} : '0);
    end
    assign nx[k] = p1[k][N+1:1];
    assign rd[k] = (acc[k] >= {1'b0, m_q}) ? N'(acc[k] - {1'b0, m_q}) : acc[k][N-1:0];
  end

  assign done_o = (st == DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= IDLE;
      cnt <= '0;
      m_q <= '0;
      s_q <= '0;
      u_q <= '0;
      e_q <= '0;
      t_q <= '0;
      i_q <= '0;
      en1 <= 1'b0;
      xa  <= '0;
      yb  <= '0;
      acc <= '0;
      z_o <= '0;
    end else begin
      if (busy && !last) begin
        cnt    <= cnt + 1'b1;
        acc[0] <= nx[0];
        xa[0]  <= xa[0] >> 1;
        if (en1) begin
          acc[1] <= nx[1];
          xa[1]  <= xa[1] >> 1;
        end
      end
      case (st)
        IDLE: if (start_i) begin
          m_q   <= mod_i;
          e_q   <= exp_i;
          t_q   <= (exp_len_i > LW'(EW)) ? LW'(EW) : exp_len_i;
          xa[0] <= base_i;
          yb[0] <= r2_i;
          xa[1] <= r2_i;
          yb[1] <= N'(1);
          acc   <= '0;
          en1   <= 1'b1;
          cnt   <= '0;
          st    <= CONV;
        end
        CONV: if (last) begin
          s_q <= rd[0];
          u_q <= rd[1];
          i_q <= '0;
          st  <= (t_q == '0) ? FIN_LD : STEP_LD;
        end
        STEP_LD: begin
          xa[0] <= s_q;
          yb[0] <= s_q;
          xa[1] <= u_q;
          yb[1] <= s_q;
          en1   <= e_q[i_q[IW-1:0]];
          acc   <= '0;
          cnt   <= '0;
          st    <= STEP;
        end
        STEP: if (last) begin
          s_q <= rd[0];
          if (en1) u_q <= rd[1];
          i_q <= i_q + 1'b1;
          st  <= (LW'(i_q + 1'b1) == t_q) ? FIN_LD : STEP_LD;
        end
        FIN_LD: begin
          xa[0]  <= N'(1);
          yb[0]  <= u_q;
          acc[0] <= '0;
          en1    <= 1'b0;
          cnt    <= '0;
          st     <= FIN;
        end
        FIN: if (last) begin
          z_o <= rd[0];
          st  <= DONE;
        end
        DONE:    st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  p_even_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |-> (!p1[0][0] && (!en1 || !p1[1][0])));

  p_acc_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (acc[0] < {m_q, 1'b0}));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_z_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != FIN) |=> $stable(z_o));

  p_busy_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ($stable(m_q) && $stable(e_q) && $stable(t_q)));

  p_u_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == STEP && !en1) |=> $stable(u_q));

  p_s_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == STEP && !last) |=> $stable(s_q));
endmodule

// File: tb/test_mont_pow.sv
module test_mont_pow;
  localparam int N  = 16;
  localparam int EW = 16;
  localparam int LW = $clog2(EW+1);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0]  base = '0, md = '0, r2 = '0;
  logic [EW-1:0] ex = '0;
  logic [LW-1:0] tl = '0;
  logic [N-1:0]  z;
  logic          done;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  mont_pow #(.N(N), .EW(EW)) i_mont_pow (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .exp_i(ex),
    .mod_i(md), .r2_i(r2), .exp_len_i(tl), .z_o(z), .done_o(done)
  );

  function automatic longint ref_pow(longint x, logic [63:0] e, int t, longint m);
    longint r = 1 % m;
    longint b = x % m;
    for (int i = 0; i < t; i++) begin
      if (e[i]) r = (r * b) % m;
      b = (b * b) % m;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input longint x, input longint e, input longint m, input int t,
                     input bit poke, input string req);
    int tt = (t > EW) ? EW : t;
    longint want = ref_pow(x, e, tt, m);
    int lat = (tt + 2) * (N + 2);
    int cyc = 0;
    logic [N-1:0] zr;
    @(negedge clk);
    base = N'(x); ex = EW'(e); md = N'(m); tl = LW'(t);
    r2 = N'(((64'd1 << (2*N)) % m));
    start = 1'b1;
    forever begin
      @(posedge clk); cyc++; #1;
      if (cyc == 1) start = 1'b0;
      if (poke && cyc == 40) begin
        start = 1'b1; base = ~base; md = 16'd65521; ex = ~ex; tl = LW'(1);
      end
      if (poke && cyc == 41) start = 1'b0;
      if (done || cyc > 20000) break;
    end
    check(cyc == lat, {req, " R4 latency"}, cyc, lat);
    check(z == N'(want), {req, " result"}, z, want);
    check(longint'(z) < m, {req, " R10 below modulus"}, z, m);
    zr = z;
    @(posedge clk); #1;
    check(!done && z == zr, {req, " R5 pulse and hold"}, {done, z}, {1'b0, zr});
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check(done == 1'b0 && z == '0, "R7 reset state", {done, z}, 0);
    @(negedge clk); rst_n = 1'b1;

    run(2, 1, 3, 1, 1'b0, "R1 small modulus");
    run(65534, 16'hFFFF, 65535, 16, 1'b0, "R1 dense exponent top modulus");
    run(0, 5, 101, 3, 1'b0, "R1 zero base");
    run(1234, 16'hBEEF, 40001, 0, 1'b0, "R3 empty exponent");
    run(777, 16'hFF00, 60001, 8, 1'b0, "R2 high bits hidden");
    run(4321, 16'h1357, 50021, 20, 1'b0, "R2 length clamp");
    run(999, 1, 62003, 16, 1'b0, "R8 only bit 0");
    run(999, 16'h8000, 62003, 16, 1'b0, "R8 only top bit");
    run(31337, 16'hA5C3, 54321, 16, 1'b1, "R6 start while busy");

    for (int k = 0; k < 40; k++) begin
      longint m = longint'($urandom & 32'hFFFF) | 1;
      longint x, e;
      int t;
      if (m < 3) m = 3;
      x = longint'($urandom) % m;
      e = longint'($urandom & 32'hFFFF);
      t = 1 + int'($urandom % EW);
      run(x, e, m, t, 1'b0, "R1 R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule